// File: doc/BRIEF.md
# Multi-Layer Bus Crossbar with Per-Slave Default Master

This block joins four bus masters to five bus slaves over a simple single-transfer bus. Each port carries a request, an address, a write flag, write data, read data and a ready. Every master has its own address decoder, and all decoders use one shared map. A master that targets a slave no other master is using gets its own path to that slave. Masters that address different slaves therefore transfer in the same cycles.

Each slave has its own arbiter. The arbiter picks among the masters that request that slave, in round-robin order. It then holds the grant until the slave signals ready. The arbiter also remembers a default master, which is the master it granted last. The default master is routed straight to the slave in the cycle it requests. Any other master first spends one connection cycle before its transfer reaches the slave. A master keeps its request, address and data steady until it sees ready.

Top module: `xbar_crossbar`

## Requirements
- R1: Masters that address different slaves are served in parallel: when each is the default master of its target, all of them see ready in the cycle they first request.
- R2: The slave index is the address field [31:29]. Values 0 to 4 select slaves 0 to 4. A read returns the selected slave's read data.
- R3: An address whose field [31:29] is 5, 6 or 7 is unmapped. A request to it sees ready in the same cycle with read data zero.
- R4: Each slave grants at most one master at a time. An idle slave picks among its requesters in round-robin order, starting at the master after its default master.
- R5: A grant holds until the slave asserts ready. While a selected slave holds ready low, its select and grant stay unchanged.
- R6: When the slave is idle and its default master is the round-robin winner, the transfer reaches the slave in the same cycle, adding zero cycles.
- R7: Any other winning master is connected one cycle later, so ready is held low for one added cycle.
- R8: The default master of a slave is the master it granted last. After reset it is master 0 for every slave.
- R9: Ready and read data go only to the master granted on that slave. A master waiting for arbitration or connection sees ready low.
- R10: After reset, with no requests, no slave is selected and no master sees ready.
- R11: A write carries its address and data unchanged to the addressed slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | NM | Per-master transfer request |
| m_addr | input | NM x AW | Per-master address |
| m_write | input | NM | Per-master write flag (1 = write) |
| m_wdata | input | NM x DW | Per-master write data |
| m_rdata | output | NM x DW | Per-master read data |
| m_ready | output | NM | Per-master transfer complete |
| s_sel | output | NS | Per-slave select, transfer presented |
| s_addr | output | NS x AW | Per-slave forwarded address |
| s_write | output | NS | Per-slave forwarded write flag |
| s_wdata | output | NS x DW | Per-slave forwarded write data |
| s_rdata | input | NS x DW | Per-slave read data |
| s_ready | input | NS | Per-slave transfer complete |

## Verification
The hardest case to reach is several masters contending for one slave that inserts wait states. Only there do the round-robin order, the update of the default master and the holding of a grant all act at once.

The bench sends three masters to the same slave in the same cycle, while that slave's default master is a fourth one. The slave model adds two wait states. Each master's ready arrives at a distinct cycle count, so the measured latencies reveal the grant order and the one-cycle connection penalty. A second two-master race on another slave shows that a requesting default master is passed over in favour of the next master in round-robin order.

// File: rtl/xbar_pkg.sv
// Shared types for the crossbar.
// Assumes: nothing beyond the standard.
package xbar_pkg;
    // Per-slave arbiter phase: idle (free to arbitrate) or busy (grant held)
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_t;
endpackage

// File: rtl/xbar_decoder.sv
// Address decoder for one master: turns the slave-index field of the
// address into a one-hot slave request, or flags the address unmapped.
// Assumes: index values at or above NS have no slave behind them.
module xbar_decoder #(
    parameter int NS   = 5,
    parameter int SELW = 3
) (
    input  logic            req,
    input  logic [SELW-1:0] sel_bits,
    output logic [NS-1:0]   hit,
    output logic            unmapped
);
    // Compare the index field against every slave number
    always_comb begin
        hit = '0;
        for (int s = 0; s < NS; s++) begin
            hit[s] = req && (int'(sel_bits) == s);
        end
        unmapped = req && (int'(sel_bits) >= NS);
    end
endmodule

// File: rtl/xbar_arbiter.sv
// Per-slave arbiter and forward multiplexer. It keeps a default master,
// which is the last one granted and master 0 after reset. An idle slave picks
// a winner in round-robin order starting after the default. A winner that
// equals the default is presented at once. Any other winner becomes the
// default and is presented from the next cycle. The grant holds until s_ready.
// Assumes: a master keeps req, address and data stable until it sees ready.
module xbar_arbiter
    import xbar_pkg::*;
#(
    parameter int NM = 4,
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          req,
    input  logic [NM-1:0][AW-1:0]  m_addr,
    input  logic [NM-1:0]          m_write,
    input  logic [NM-1:0][DW-1:0]  m_wdata,
    input  logic                   s_ready,
    output logic [NM-1:0]          gnt,
    output logic                   s_sel,
    output logic [AW-1:0]          s_addr,
    output logic                   s_write,
    output logic [DW-1:0]          s_wdata
);
    localparam int MIW = (NM > 1) ? $clog2(NM) : 1;

    arb_state_t     st_q, st_d;
    logic [MIW-1:0] dflt_q, dflt_d;
    logic [MIW-1:0] win;
    logic [MIW-1:0] cand;
    logic           found;
    logic           any;
    logic           present;

    // Round-robin winner, searching from the master after the default
    always_comb begin
        win   = dflt_q;
        cand  = dflt_q;
        found = 1'b0;
        for (int i = 1; i <= NM; i++) begin
            cand = MIW'((int'(dflt_q) + i) % NM);
            if (!found && req[cand]) begin
                win   = cand;
                found = 1'b1;
            end
        end
        any = |req;
    end

    // Present the default master when busy or when it wins an idle slave
    always_comb begin
        present = (st_q == ARB_BUSY) || (any && (win == dflt_q));
        gnt     = present ? (NM'(1) << dflt_q) : '0;
        s_sel   = present;
        s_addr  = m_addr[dflt_q];
        s_write = m_write[dflt_q];
        s_wdata = m_wdata[dflt_q];
    end

    // Next phase and default master
    always_comb begin
        st_d   = st_q;
        dflt_d = dflt_q;
        case (st_q)
            ARB_IDLE: begin
                if (any) begin
                    if (win == dflt_q) begin
                        if (!s_ready) st_d = ARB_BUSY;
                    end else begin
                        st_d   = ARB_BUSY;
                        dflt_d = win;
                    end
                end
            end
            default: begin
                if (s_ready) st_d = ARB_IDLE;
            end
        endcase
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ARB_IDLE;
            dflt_q <= '0;
        end else begin
            st_q   <= st_d;
            dflt_q <= dflt_d;
        end
    end
endmodule

// File: rtl/xbar_resp.sv
// Response router: returns ready and read data to the master granted on
// each slave. Unmapped requests see ready with zero data.
// Assumes: each arbiter grant vector is one-hot or zero, and each master
// is granted on at most one slave.
module xbar_resp #(
    parameter int NM = 4,
    parameter int NS = 5,
    parameter int DW = 32
) (
    input  logic [NS-1:0][NM-1:0] gnt,
    input  logic [NS-1:0]         s_ready,
    input  logic [NS-1:0][DW-1:0] s_rdata,
    input  logic [NM-1:0]         unmapped,
    output logic [NM-1:0]         m_ready,
    output logic [NM-1:0][DW-1:0] m_rdata
);
    // OR together the responses of slaves granting each master
    always_comb begin
        for (int m = 0; m < NM; m++) begin
            m_ready[m] = unmapped[m];
            m_rdata[m] = '0;
            for (int s = 0; s < NS; s++) begin
                if (gnt[s][m]) begin
                    m_ready[m] = m_ready[m] | s_ready[s];
                    m_rdata[m] = m_rdata[m] | s_rdata[s];
                end
            end
        end
    end
endmodule

// File: rtl/xbar_crossbar.sv
// Top of the crossbar: one decoder per master, one arbiter per slave and a
// response router. Slave requests are the transposed decoder hit matrix.
// Assumes: NS <= 2**SELW; the index field is the top SELW address bits.
module xbar_crossbar #(
    parameter int NM   = 4,
    parameter int NS   = 5,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int SELW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          m_req,
    input  logic [NM-1:0][AW-1:0]  m_addr,
    input  logic [NM-1:0]          m_write,
    input  logic [NM-1:0][DW-1:0]  m_wdata,
    output logic [NM-1:0][DW-1:0]  m_rdata,
    output logic [NM-1:0]          m_ready,
    output logic [NS-1:0]          s_sel,
    output logic [NS-1:0][AW-1:0]  s_addr,
    output logic [NS-1:0]          s_write,
    output logic [NS-1:0][DW-1:0]  s_wdata,
    input  logic [NS-1:0][DW-1:0]  s_rdata,
    input  logic [NS-1:0]          s_ready
);
    logic [NM-1:0][NS-1:0] hit;
    logic [NS-1:0][NM-1:0] sreq;
    logic [NS-1:0][NM-1:0] gnt;
    logic [NM-1:0]         unmapped;

    // Per-master decoders
    for (genvar m = 0; m < NM; m++) begin : g_dec
        xbar_decoder #(.NS(NS), .SELW(SELW)) u_dec (
            .req      (m_req[m]),
            .sel_bits (m_addr[m][AW-1 -: SELW]),
            .hit      (hit[m]),
            .unmapped (unmapped[m])
        );
    end

    // Transpose master hits into per-slave request vectors
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < NM; m++) begin
                sreq[s][m] = hit[m][s];
            end
        end
    end

    // Per-slave arbiters
    for (genvar s = 0; s < NS; s++) begin : g_arb
        xbar_arbiter #(.NM(NM), .AW(AW), .DW(DW)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (sreq[s]),
            .m_addr  (m_addr),
            .m_write (m_write),
            .m_wdata (m_wdata),
            .s_ready (s_ready[s]),
            .gnt     (gnt[s]),
            .s_sel   (s_sel[s]),
            .s_addr  (s_addr[s]),
            .s_write (s_write[s]),
            .s_wdata (s_wdata[s])
        );
    end

    xbar_resp #(.NM(NM), .NS(NS), .DW(DW)) u_resp (
        .gnt      (gnt),
        .s_ready  (s_ready),
        .s_rdata  (s_rdata),
        .unmapped (unmapped),
        .m_ready  (m_ready),
        .m_rdata  (m_rdata)
    );
endmodule

// File: rtl/xbar_checker.sv
// Property checker for the crossbar, bound to every instance of the top.
// Assumes: masters hold their request steady until ready.
module xbar_checker #(
    parameter int NM   = 4,
    parameter int NS   = 5,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int SELW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NM-1:0]          m_req,
    input  logic [NM-1:0][AW-1:0]  m_addr,
    input  logic [NM-1:0]          m_ready,
    input  logic [NM-1:0][DW-1:0]  m_rdata,
    input  logic [NS-1:0]          s_sel,
    input  logic [NS-1:0]          s_ready,
    input  logic [NS-1:0][NM-1:0]  gnt
);
    for (genvar s = 0; s < NS; s++) begin : g_slv
        // R4: at most one master granted per slave
        p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt[s]));
        // R5: a stalled transfer keeps its select and grant
        p_hold_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (s_sel[s] && !s_ready[s]) |=> (s_sel[s] && $stable(gnt[s])));
    end

    for (genvar m = 0; m < NM; m++) begin : g_mst
        // R3: unmapped request completes at once with zero data
        p_unmapped_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (m_req[m] && (int'(m_addr[m][AW-1 -: SELW]) >= NS))
            |-> (m_ready[m] && (m_rdata[m] == '0)));
        // R9: no response to a master that is not requesting
        p_no_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !m_req[m] |-> !m_ready[m]);
        for (genvar s = 0; s < NS; s++) begin : g_pair
            // R9: ready only through the grant on the addressed slave
            p_ready_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (m_ready[m] && (int'(m_addr[m][AW-1 -: SELW]) == s))
                |-> (gnt[s][m] && s_ready[s]));
        end
    end
endmodule

bind xbar_crossbar xbar_checker #(
    .NM(NM), .NS(NS), .AW(AW), .DW(DW), .SELW(SELW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_req   (m_req),
    .m_addr  (m_addr),
    .m_ready (m_ready),
    .m_rdata (m_rdata),
    .s_sel   (s_sel),
    .s_ready (s_ready),
    .gnt     (gnt)
);

// File: tb/xbar_crossbar_tb.sv
`timescale 1ns/1ps
module xbar_crossbar_tb;
    localparam int NM = 4;
    localparam int NS = 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NM-1:0]        m_req = '0;
    logic [NM-1:0][31:0]  m_addr = '0;
    logic [NM-1:0]        m_write = '0;
    logic [NM-1:0][31:0]  m_wdata = '0;
    logic [NM-1:0][31:0]  m_rdata;
    logic [NM-1:0]        m_ready;
    logic [NS-1:0]        s_sel;
    logic [NS-1:0][31:0]  s_addr;
    logic [NS-1:0]        s_write;
    logic [NS-1:0][31:0]  s_wdata;
    logic [NS-1:0][31:0]  s_rdata;
    logic [NS-1:0]        s_ready;

    logic [NS-1:0][1:0]   wcnt;
    logic [NS-1:0][31:0]  last_wa;
    logic [NS-1:0][31:0]  last_wd;

    logic [31:0] expq [NM][$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xbar_crossbar u_dut (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_addr(m_addr), .m_write(m_write), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready),
        .s_sel(s_sel), .s_addr(s_addr), .s_write(s_write), .s_wdata(s_wdata),
        .s_rdata(s_rdata), .s_ready(s_ready)
    );

    function automatic int wait_of(int s);
        return (s == 2) ? 2 : 0;
    endfunction

    function automatic logic [31:0] rd_val(int s, logic [31:0] a);
        return {4'(s), 4'hA, a[23:0]};
    endfunction

    // Slave models: slave 2 inserts two wait states, others are immediate
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            s_ready[s] = s_sel[s] && (int'(wcnt[s]) == wait_of(s));
            s_rdata[s] = rd_val(s, s_addr[s]);
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (s_sel[s] && !s_ready[s]) wcnt[s] <= wcnt[s] + 2'd1;
            else                         wcnt[s] <= '0;
            if (s_sel[s] && s_ready[s] && s_write[s]) begin
                last_wa[s] <= s_addr[s];
                last_wd[s] <= s_wdata[s];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: queue the expected read data, run one transfer, check latency
    task automatic xfer(input int m, input logic [31:0] a, input logic we,
                        input logic [31:0] wd, input int exp_lat, input string tag);
        int lat;
        int idx;
        idx = int'(a[31:29]);
        if (!we) expq[m].push_back((idx >= NS) ? 32'h0 : rd_val(idx, a));
        @(posedge clk);
        #1;
        m_req[m] = 1'b1;
        m_addr[m] = a;
        m_write[m] = we;
        m_wdata[m] = wd;
        lat = 0;
        forever begin
            @(negedge clk);
            if (m_ready[m]) break;
            lat++;
            if (lat > 100) break;
        end
        check(lat == exp_lat, tag, 32'(lat), 32'(exp_lat));
        @(posedge clk);
        #1;
        m_req[m] = 1'b0;
        m_write[m] = 1'b0;
    endtask

    // Monitor: compare each completed read against the scoreboard queue
    always @(negedge clk) begin
        for (int m = 0; m < NM; m++) begin
            if (rst_n && m_req[m] && m_ready[m] && !m_write[m]) begin
                if (expq[m].size() == 0) begin
                    check(1'b0, "R2 unexpected read response", m_rdata[m], 32'h0);
                end else begin
                    logic [31:0] e;
                    e = expq[m].pop_front();
                    check(m_rdata[m] == e, "R2 R3 read data", m_rdata[m], e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(s_sel == '0, "R10 no slave selected", 32'(s_sel), 32'h0);
        check(m_ready == '0, "R10 no master ready", 32'(m_ready), 32'h0);

        // R6 R8: master 0 is default after reset
        xfer(0, 32'h0000_0040, 1'b0, 32'h0, 0, "R6 R8 default m0 s0");
        // R7: non-default pays one cycle
        xfer(1, 32'h2000_0010, 1'b0, 32'h0, 1, "R7 m1 s1");
        // R8: last granted becomes default
        xfer(1, 32'h2000_0014, 1'b0, 32'h0, 0, "R8 m1 s1 now default");
        xfer(0, 32'h2000_0018, 1'b0, 32'h0, 1, "R7 R8 m0 s1 back");

        // R1: make m1 default of s3 and m2 default of s4, then run in parallel
        xfer(1, 32'h6000_0000, 1'b0, 32'h0, 1, "R7 m1 s3");
        xfer(2, 32'h8000_0004, 1'b0, 32'h0, 1, "R7 m2 s4");
        fork
            xfer(0, 32'h0000_0100, 1'b0, 32'h0, 0, "R1 parallel m0 s0");
            xfer(1, 32'h6000_0200, 1'b0, 32'h0, 0, "R1 parallel m1 s3");
            xfer(2, 32'h8000_0300, 1'b0, 32'h0, 0, "R1 parallel m2 s4");
            xfer(3, 32'hA000_0000, 1'b0, 32'h0, 0, "R1 R3 parallel m3 unmapped");
        join

        // R4 R5 R9: three masters contend for s2 (two wait states, default m0)
        fork
            xfer(1, 32'h4000_0000, 1'b0, 32'h0, 3, "R4 R5 m1 first on s2");
            xfer(2, 32'h4000_0004, 1'b0, 32'h0, 7, "R4 R9 m2 waits on s2");
            xfer(3, 32'h4000_0008, 1'b0, 32'h0, 11, "R4 R9 m3 waits on s2");
        join

        // R4: requesting default is passed over for the next master
        fork
            xfer(0, 32'h0000_0200, 1'b0, 32'h0, 3, "R4 R9 m0 default loses");
            xfer(1, 32'h0000_0204, 1'b0, 32'h0, 1, "R4 m1 wins s0");
        join

        // R3: unmapped top value
        xfer(3, 32'hE000_1234, 1'b0, 32'h0, 0, "R3 unmapped m3");

        // R11: write forwarded to slave 1 (default there is m0)
        xfer(2, 32'h2000_0020, 1'b1, 32'hDEAD_BEEF, 1, "R7 R11 write m2 s1");
        @(negedge clk);
        check(last_wa[1] == 32'h2000_0020, "R11 write address", last_wa[1], 32'h2000_0020);
        check(last_wd[1] == 32'hDEAD_BEEF, "R11 write data", last_wd[1], 32'hDEAD_BEEF);

        for (int m = 0; m < NM; m++) begin
            check(expq[m].size() == 0, "R9 all reads answered", 32'(expq[m].size()), 32'h0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule